// File: doc/BRIEF.md
# Serial Status LED Frame Driver

This block turns a hub's status bits into a serial LED stream. On a fixed refresh interval it sends one burst of sixteen clock pulses on a dedicated LED clock. Three data lines carry sixteen bits each, to be captured by external serial-in, parallel-out shift registers that drive the lamps. The status covers per-port jabber, partition and activity, global partition, RAM-test failure, the two collision indicators, and the 10 Mb/s and 100 Mb/s utilization percentages. Each percentage becomes an eight-segment bar on a nonlinear scale. Every data bit is active low: a lit lamp is a 0 on the line.

Status is captured once at the start of each burst, so no frame mixes old and new values. Data moves on the falling LED clock edge, giving the external registers a half period of setup and hold around the rising edge. After reset the block runs a lamp test: all lamps on, off, on, then a shorter dark phase, then normal display. The burst interval, the LED clock half period and the lamp-test phase lengths are parameters counted in system clock cycles.

Top module: `stat_led_shifter`

## Requirements
- R1: While rst_n is low, led_clk_o is 0 and all three led_dat_o lines are 1. The lamp test begins at reset release.
- R2: Each burst has exactly 16 rising edges of led_clk_o. Each high phase and each low phase inside a burst lasts LED_HALF_CYC system cycles, and the LED clock stays low between bursts.
- R3: Bursts start every FRAME_CYC system cycles. The first burst starts on the first clock edge after reset release.
- R4: led_dat_o changes only while led_clk_o is low, at the start of a burst or on a falling edge. It is stable for the LED_HALF_CYC cycles before each rising edge and throughout each high phase.
- R5: Line 0 sends D0..D4 = jabber of ports 4..0, then D5..D9 = partition of ports 4..0, then D10..D15 = 1. A set status bit is sent as 0.
- R6: Line 1 sends D0 = constant 0, D1 = global partition, D2 = RAM-test fail, D3 = 10 Mb/s collision, D4 = 100 Mb/s collision, D5..D9 = activity of ports 4..0, then D10..D15 = 1. All are active low.
- R7: Line 2 sends D0..D7 = 10 Mb/s bar segments 7..0, then D8..D15 = 100 Mb/s bar segments 7..0.
- R8: Bar segment k (k = 0..7) is lit (sent as 0) when the percentage is at least the k-th value of 1, 5, 10, 15, 30, 40, 60, 80. Otherwise it is sent as 1. The inputs are 7 bits wide, and any value from 80 to 127 lights all eight segments.
- R9: A burst that starts within LAMP_CYC cycles of reset release is all 0 on all lines. Bursts in the next LAMP_CYC cycles are all 1. Bursts in the LAMP_CYC cycles after that are all 0. Bursts in the next LAMP_DARK_CYC cycles are all 1. Later bursts carry status.
- R10: Status inputs are sampled only on the cycle a burst starts. A change during a burst shows only in the next burst.
- R11: Between bursts all three data lines are held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jab_i | input | 5 | Per-port jabber status |
| part_i | input | 5 | Per-port partition status |
| act_i | input | 5 | Per-port activity status |
| gpart_i | input | 1 | Global partition status |
| ramfail_i | input | 1 | Buffer RAM test failure |
| col10_i | input | 1 | 10 Mb/s collision indicator |
| col100_i | input | 1 | 100 Mb/s collision indicator |
| util10_i | input | 7 | 10 Mb/s utilization percent |
| util100_i | input | 7 | 100 Mb/s utilization percent |
| led_clk_o | output | 1 | Burst LED shift clock |
| led_dat_o | output | 3 | Serial LED data lines, active low |

## Verification
The assertions watch the LED clock waveform on every cycle. They check the reset state, high phases of exactly one half period, at most sixteen rising edges per burst, and data held still both into and through each high phase. Bit placement on each line, the threshold of each bar segment, the lamp-test sequence and its timing, the burst period and the capture of status at burst start depend on what was presented and when. Only the bench scenarios show these: the bench decodes whole frames and compares them with frames built from the requirements.

// File: rtl/stat_led_pkg.sv
package stat_led_pkg;

  localparam int PORTS      = 5;
  localparam int FRAME_BITS = 16;
  localparam int LINES      = 3;
  localparam int SEGS       = 8;
  localparam int PCT_W      = 7;
  localparam int HDR1       = 5;   // fixed/global bits ahead of activity on line 1

  typedef enum logic [2:0] {
    LT_ON_A,
    LT_OFF_A,
    LT_ON_B,
    LT_OFF_B,
    LT_RUN
  } lamp_e;

  typedef logic [LINES-1:0][FRAME_BITS-1:0] frame_t;

  // Percent at which bar segment idx turns on (R8)
  function automatic logic [PCT_W-1:0] seg_threshold(input int idx);
    case (idx)
      0:       return PCT_W'(1);
      1:       return PCT_W'(5);
      2:       return PCT_W'(10);
      3:       return PCT_W'(15);
      4:       return PCT_W'(30);
      5:       return PCT_W'(40);
      6:       return PCT_W'(60);
      default: return PCT_W'(80);
    endcase
  endfunction

endpackage

// File: rtl/util_bar.sv
module util_bar
  import stat_led_pkg::*;
#(
  parameter int NSEG = SEGS
) (
  input  logic [PCT_W-1:0] pct_i,
  output logic [NSEG-1:0]  bar_n_o
);

  // R8: one comparator per segment, lit segment driven low
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign bar_n_o[k] = (pct_i >= seg_threshold(k)) ? 1'b0 : 1'b1;
  end

endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import stat_led_pkg::*;
#(
  parameter int FRAME_CYC     = 3125000,
  parameter int LAMP_CYC      = 20960000,
  parameter int LAMP_DARK_CYC = 10480000
) (
  input  logic  clk,
  input  logic  rst_n,
  output logic  start_o,
  output lamp_e lamp_o
);

  localparam int FW    = $clog2(FRAME_CYC + 1);
  localparam int LMAX  = (LAMP_CYC > LAMP_DARK_CYC) ? LAMP_CYC : LAMP_DARK_CYC;
  localparam int LW    = $clog2(LMAX + 1);

  logic [FW-1:0] fcnt;
  logic [LW-1:0] lcnt;
  logic [LW-1:0] phase_last;
  lamp_e         state;

  // R3: free-running refresh counter, burst on count zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (fcnt == FW'(FRAME_CYC - 1)) begin
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign start_o = (fcnt == '0);

  // R9: lamp-test sequencer
  assign phase_last = (state == LT_OFF_B) ? LW'(LAMP_DARK_CYC - 1) : LW'(LAMP_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LT_ON_A;
      lcnt  <= '0;
    end else if (state != LT_RUN) begin
      if (lcnt == phase_last) begin
        lcnt <= '0;
        case (state)
          LT_ON_A:  state <= LT_OFF_A;
          LT_OFF_A: state <= LT_ON_B;
          LT_ON_B:  state <= LT_OFF_B;
          default:  state <= LT_RUN;
        endcase
      end else begin
        lcnt <= lcnt + 1'b1;
      end
    end
  end

  assign lamp_o = state;

endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import stat_led_pkg::*;
(
  input  lamp_e            lamp_i,
  input  logic [PORTS-1:0] jab_i,
  input  logic [PORTS-1:0] part_i,
  input  logic [PORTS-1:0] act_i,
  input  logic             gpart_i,
  input  logic             ramfail_i,
  input  logic             col10_i,
  input  logic             col100_i,
  input  logic [PCT_W-1:0] util10_i,
  input  logic [PCT_W-1:0] util100_i,
  output frame_t           frame_o
);

  logic [FRAME_BITS-1:0] ln0, ln1, ln2;
  logic [SEGS-1:0]       bar10_n, bar100_n;

  util_bar #(.NSEG(SEGS)) u_bar10  (.pct_i(util10_i),  .bar_n_o(bar10_n));
  util_bar #(.NSEG(SEGS)) u_bar100 (.pct_i(util100_i), .bar_n_o(bar100_n));

  // R5, R6: per-port fields, highest port first
  for (genvar i = 0; i < PORTS; i++) begin : g_port
    assign ln0[i]         = ~jab_i[PORTS-1-i];
    assign ln0[PORTS+i]   = ~part_i[PORTS-1-i];
    assign ln1[HDR1+i]    = ~act_i[PORTS-1-i];
  end
  for (genvar i = 2*PORTS; i < FRAME_BITS; i++) begin : g_pad0
    assign ln0[i] = 1'b1;
  end
  for (genvar i = HDR1 + PORTS; i < FRAME_BITS; i++) begin : g_pad1
    assign ln1[i] = 1'b1;
  end

  assign ln1[0] = 1'b0;
  assign ln1[1] = ~gpart_i;
  assign ln1[2] = ~ramfail_i;
  assign ln1[3] = ~col10_i;
  assign ln1[4] = ~col100_i;

  // R7: top segment first, 10 Mb/s bar then 100 Mb/s bar
  for (genvar i = 0; i < SEGS; i++) begin : g_bar
    assign ln2[i]      = bar10_n[SEGS-1-i];
    assign ln2[SEGS+i] = bar100_n[SEGS-1-i];
  end

  always_comb begin
    case (lamp_i)
      LT_ON_A, LT_ON_B:   frame_o = '0;
      LT_OFF_A, LT_OFF_B: frame_o = '1;
      default: begin
        frame_o[0] = ln0;
        frame_o[1] = ln1;
        frame_o[2] = ln2;
      end
    endcase
  end

endmodule

// File: rtl/burst_shifter.sv
module burst_shifter
  import stat_led_pkg::*;
#(
  parameter int HALF_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  frame_t           frame_i,
  output logic             led_clk_o,
  output logic [LINES-1:0] led_dat_o
);

  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(FRAME_BITS);

  logic          busy;
  logic          clk_q;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bcnt;
  frame_t        sh;

  // R10: frame captured only when a burst starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      clk_q <= 1'b0;
      hcnt  <= '0;
      bcnt  <= '0;
      sh    <= '1;
    end else if (!busy) begin
      if (start_i) begin
        busy  <= 1'b1;
        clk_q <= 1'b0;
        hcnt  <= '0;
        bcnt  <= '0;
        sh    <= frame_i;
      end
    end else if (hcnt == HW'(HALF_CYC - 1)) begin
      hcnt  <= '0;
      clk_q <= ~clk_q;
      if (clk_q) begin
        // R4: advance data on the falling edge only
        for (int l = 0; l < LINES; l++) begin
          sh[l] <= {1'b1, sh[l][FRAME_BITS-1:1]};
        end
        bcnt <= bcnt + 1'b1;
        if (bcnt == BW'(FRAME_BITS - 1)) begin
          busy <= 1'b0;   // R2: stop after sixteen pulses
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign led_clk_o = clk_q;

  // R11: idle lines rest high
  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign led_dat_o[l] = busy ? sh[l][0] : 1'b1;
  end

endmodule

// File: rtl/stat_led_shifter.sv
module stat_led_shifter
  import stat_led_pkg::*;
#(
  parameter int LED_HALF_CYC  = 1,
  parameter int FRAME_CYC     = 3125000,
  parameter int LAMP_CYC      = 20960000,
  parameter int LAMP_DARK_CYC = 10480000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       jab_i,
  input  logic [4:0]       part_i,
  input  logic [4:0]       act_i,
  input  logic             gpart_i,
  input  logic             ramfail_i,
  input  logic             col10_i,
  input  logic             col100_i,
  input  logic [6:0]       util10_i,
  input  logic [6:0]       util100_i,
  output logic             led_clk_o,
  output logic [2:0]       led_dat_o
);

  logic   start;
  lamp_e  lamp;
  frame_t frame;

  frame_timer #(
    .FRAME_CYC    (FRAME_CYC),
    .LAMP_CYC     (LAMP_CYC),
    .LAMP_DARK_CYC(LAMP_DARK_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_o(start),
    .lamp_o (lamp)
  );

  frame_builder u_build (
    .lamp_i   (lamp),
    .jab_i    (jab_i),
    .part_i   (part_i),
    .act_i    (act_i),
    .gpart_i  (gpart_i),
    .ramfail_i(ramfail_i),
    .col10_i  (col10_i),
    .col100_i (col100_i),
    .util10_i (util10_i),
    .util100_i(util100_i),
    .frame_o  (frame)
  );

  burst_shifter #(.HALF_CYC(LED_HALF_CYC)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .frame_i  (frame),
    .led_clk_o(led_clk_o),
    .led_dat_o(led_dat_o)
  );

endmodule

// File: rtl/stat_led_shifter_chk.sv
module stat_led_shifter_chk #(
  parameter int HALF_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       led_clk_o,
  input logic [2:0] led_dat_o
);

  logic        clk_d;
  logic [31:0] low_run;
  logic [31:0] high_run;
  logic [5:0]  rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      low_run  <= '0;
      high_run <= '0;
      rise_cnt <= '0;
    end else begin
      clk_d <= led_clk_o;
      if (led_clk_o) begin
        low_run  <= '0;
        if (high_run != '1) high_run <= high_run + 1'b1;
      end else begin
        high_run <= '0;
        if (low_run != '1) low_run <= low_run + 1'b1;
      end
      if (led_clk_o && !clk_d) begin
        if (low_run > 32'(HALF_CYC)) rise_cnt <= 6'd1;
        else if (rise_cnt != '1)     rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_idle_r1: assert (led_clk_o == 1'b0 && led_dat_o == 3'b111);
    end
  end

  p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    led_clk_o |-> (high_run < 32'(HALF_CYC)));

  p_rise_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= 6'd16);

  p_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_clk_o && clk_d) |-> $stable(led_dat_o));

  p_rise_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_clk_o) |-> $stable(led_dat_o));

endmodule

bind stat_led_shifter stat_led_shifter_chk #(.HALF_CYC(LED_HALF_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .led_clk_o(led_clk_o),
  .led_dat_o(led_dat_o)
);

// File: tb/stat_led_shifter_test.sv
module stat_led_shifter_test;

  localparam int CLK_PERIOD  = 10;
  localparam int HALF        = 2;
  localparam int FRAME       = 80;
  localparam int LAMP        = 400;
  localparam int DARK        = 200;
  localparam int LAMP_FRAMES = (3*LAMP + DARK + FRAME - 1) / FRAME;
  localparam int NV          = 26;
  localparam int NDIR        = 18;
  localparam int MID_K       = 20;
  localparam int THR [8]     = '{1, 5, 10, 15, 30, 40, 60, 80};
  localparam int DIR [NDIR]  = '{0, 1, 4, 5, 9, 10, 14, 15, 29, 30, 39, 40, 59, 60, 79, 80, 100, 127};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] jab, part, act;
  logic       gpart, ramfail, col10, col100;
  logic [6:0] util10, util100;
  logic       led_clk;
  logic [2:0] led_dat;

  int checks = 0;
  int fails = 0;
  int frames_done = 0;
  int nrise = 0;
  int cyc = 0;
  int first_prev = 0;
  int mid_frame = -1;
  bit finished = 0;
  logic clk_prev = 1'b0;
  logic [2:0] dat_prev = 3'b111;
  logic [2:0][15:0] rx;
  logic [4:0] s_jab, s_part, s_act;
  logic       s_gpart, s_ramfail, s_col10, s_col100;
  logic [6:0] s_u10, s_u100;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_led_shifter #(
    .LED_HALF_CYC (HALF),
    .FRAME_CYC    (FRAME),
    .LAMP_CYC     (LAMP),
    .LAMP_DARK_CYC(DARK)
  ) uut (
    .clk(clk), .rst_n(rst_n), .jab_i(jab), .part_i(part), .act_i(act),
    .gpart_i(gpart), .ramfail_i(ramfail), .col10_i(col10), .col100_i(col100),
    .util10_i(util10), .util100_i(util100),
    .led_clk_o(led_clk), .led_dat_o(led_dat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] bar(input logic [6:0] u);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = (int'(u) >= THR[k]) ? 1'b0 : 1'b1;
    return b;
  endfunction

  function automatic logic [15:0] exp_line(input int ln);
    logic [15:0] v = '1;
    logic [7:0] b10 = bar(s_u10);
    logic [7:0] b100 = bar(s_u100);
    case (ln)
      0: for (int i = 0; i < 5; i++) begin
           v[i] = ~s_jab[4-i];
           v[5+i] = ~s_part[4-i];
         end
      1: begin
           v[0] = 1'b0; v[1] = ~s_gpart; v[2] = ~s_ramfail;
           v[3] = ~s_col10; v[4] = ~s_col100;
           for (int i = 0; i < 5; i++) v[5+i] = ~s_act[4-i];
         end
      default: for (int i = 0; i < 8; i++) begin
           v[i] = b10[7-i];
           v[8+i] = b100[7-i];
         end
    endcase
    return v;
  endfunction

  task automatic check_frame(input int f);
    int st = f * FRAME;
    if (st < 3*LAMP + DARK) begin
      logic [15:0] e = (st < LAMP || (st >= 2*LAMP && st < 3*LAMP)) ? 16'h0000 : 16'hFFFF;
      for (int l = 0; l < 3; l++)
        chk(rx[l] == e, "R9", $sformatf("lamp frame %0d line %0d", f, l), 64'(rx[l]), 64'(e));
    end else begin
      chk(rx[0] == exp_line(0), "R5", $sformatf("frame %0d line0", f), 64'(rx[0]), 64'(exp_line(0)));
      chk(rx[1] == exp_line(1), "R6", $sformatf("frame %0d line1", f), 64'(rx[1]), 64'(exp_line(1)));
      chk(rx[2] == exp_line(2), "R7 R8", $sformatf("frame %0d line2 u10=%0d u100=%0d", f, s_u10, s_u100),
          64'(rx[2]), 64'(exp_line(2)));
      if (f == mid_frame)
        chk({rx[2], rx[1], rx[0]} == {exp_line(2), exp_line(1), exp_line(0)}, "R10",
            "frame sampled at burst start", 64'({rx[2], rx[1], rx[0]}),
            64'({exp_line(2), exp_line(1), exp_line(0)}));
    end
  endtask

  // Frame decoder: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (led_clk && !clk_prev) begin
        if (nrise == 0) begin
          s_jab = jab; s_part = part; s_act = act; s_gpart = gpart;
          s_ramfail = ramfail; s_col10 = col10; s_col100 = col100;
          s_u10 = util10; s_u100 = util100;
          if (frames_done > 0)
            chk(cyc - first_prev == FRAME, "R3", "burst period", 64'(cyc - first_prev), 64'(FRAME));
          first_prev = cyc;
        end
        if (nrise == 5)
          chk(led_dat == dat_prev, "R4", "data stable into rising edge", 64'(led_dat), 64'(dat_prev));
        for (int l = 0; l < 3; l++) rx[l][nrise] = led_dat[l];
        nrise = nrise + 1;
        if (nrise == 16) begin
          check_frame(frames_done);
          nrise = 0;
          frames_done = frames_done + 1;
        end
      end
      clk_prev = led_clk;
      dat_prev = led_dat;
    end
  end

  task automatic apply_vec(input int k);
    jab = 5'($urandom); part = 5'($urandom); act = 5'($urandom);
    {gpart, ramfail, col10, col100} = 4'($urandom);
    if (k < NDIR) begin
      util10  = 7'(DIR[k]);
      util100 = 7'(DIR[(k + 9) % NDIR]);
    end else begin
      util10  = 7'($urandom % 128);
      util100 = 7'($urandom % 128);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    apply_vec(0);
    repeat (5) @(negedge clk);
    chk(led_clk == 1'b0 && led_dat == 3'b111, "R1", "reset outputs",
        64'({led_clk, led_dat}), 64'({1'b0, 3'b111}));
    rst_n = 1'b1;
    for (int k = 1; k < NV; k++) begin
      wait (frames_done == LAMP_FRAMES + k);
      repeat (4) @(negedge clk);
      chk(led_clk == 1'b0, "R2", "clock idle low between bursts", 64'(led_clk), 64'(0));
      chk(led_dat == 3'b111, "R11", "data idle high between bursts", 64'(led_dat), 64'(3'b111));
      apply_vec(k);
      if (k == MID_K) begin
        mid_frame = LAMP_FRAMES + k;
        wait (nrise == 3);
        @(negedge clk);
        jab = ~jab; part = ~part; act = ~act; gpart = ~gpart;
        util10 = 7'd127 - util10; util100 = 7'd127 - util100;
      end
    end
    wait (frames_done == LAMP_FRAMES + NV);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d frames", frames_done, LAMP_FRAMES + NV);
    finish_run();
  end

endmodule